// File: doc/BRIEF.md
# Program Busy Status Reporter

This block keeps time for the internal page-program and chip-erase cycles of a byte-wide non-volatile store, and replaces array data with a status byte whenever the host reads while a cycle is running. A one-cycle start pulse begins either operation. Each operation then runs for a fixed number of clock cycles, set by a parameter, and needs nothing further from the host.

During a busy read the status byte reports progress in two ways. Bit 7 is the complement of what the last loaded byte will finally read back as. For a program this is the inverse of bit 7 of that byte. For an erase it is 0, because an erased location reads all ones. Bit 6 alternates on every consecutive read. The host can therefore poll with either method. When the cycle ends, reads pass the array data through unchanged.

The array and the command decoder sit outside this block. The decoder supplies the start pulses and the last loaded byte. The array supplies the read data.

Top module: `prs_top`

## Requirements
- R1: After reset `busy` is 0 and `readData` equals `arrayData`.
- R2: A `pgmStart` pulse sampled while idle makes `busy` 1 from the next clock edge, for exactly `PGM_CYCLES` clock cycles.
- R3: An `eraseStart` pulse sampled while idle makes `busy` 1 from the next clock edge, for exactly `ERASE_CYCLES` clock cycles.
- R4: During a program, `readData[7]` is the complement of `lastData[7]` as sampled with the start pulse. Later changes of `lastData` have no effect.
- R5: During an erase, `readData[7]` is 0.
- R6: Bit 6 of `readData` is 0 at the first busy read after a start. It inverts after each cycle in which `readStrobe` is 1 while busy, and holds while `readStrobe` is 0.
- R7: While busy, `readData[5:0]` is 0 whatever `arrayData` holds.
- R8: While not busy, `readData` equals `arrayData`, including when `readStrobe` is 1.
- R9: Start pulses that arrive while busy are ignored. The running duration and the value of bit 7 are unchanged.
- R10: When `pgmStart` and `eraseStart` are sampled together while idle, the erase is performed: `ERASE_CYCLES` duration and bit 7 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pgmStart | input | 1 | One-cycle pulse that starts a page program |
| eraseStart | input | 1 | One-cycle pulse that starts a chip erase |
| lastData | input | 8 | Last byte loaded before the program, sampled at start |
| readStrobe | input | 1 | High in each clock cycle of a host read |
| arrayData | input | 8 | Data from the storage array |
| busy | output | 1 | High while a program or erase cycle runs |
| readData | output | 8 | Status byte while busy, otherwise array data |

## Verification
The assertions assume that `readStrobe` stays high for exactly one clock cycle per host read, so that each high cycle counts as one consecutive read. They also assume that the start pulses are single-cycle. The bench drives every read as a one-cycle strobe, in patterns taken from fixed bit masks. It raises each start for exactly one cycle, either while idle or deliberately part-way through a running operation. The bench changes `lastData` and `arrayData` throughout each busy window, so the status byte is shown to depend only on the values captured at the start.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef struct packed {
    logic loadPgm;
    logic loadErase;
    logic flipToggle;
    logic busy;
  } prsStrobes_t;
endpackage

// File: rtl/prs_ctrl.sv
module prs_ctrl
  import prs_pkg::*;
#(
  parameter int PGM_CYCLES   = 1250000,
  parameter int ERASE_CYCLES = 6250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pgmStart,
  input  logic        eraseStart,
  input  logic        readStrobe,
  output prsStrobes_t strobes
);
  localparam int MAX_CYCLES = (PGM_CYCLES > ERASE_CYCLES) ? PGM_CYCLES : ERASE_CYCLES;
  localparam int CW = $clog2(MAX_CYCLES + 1);

  logic          busyQ;
  logic [CW-1:0] remainQ;
  logic          takeErase;
  logic          takePgm;

  assign takeErase = !busyQ && eraseStart;
  assign takePgm   = !busyQ && pgmStart && !eraseStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      remainQ <= '0;
    end else if (!busyQ) begin
      if (takeErase) begin
        busyQ   <= 1'b1;
        remainQ <= CW'(ERASE_CYCLES - 1);
      end else if (takePgm) begin
        busyQ   <= 1'b1;
        remainQ <= CW'(PGM_CYCLES - 1);
      end
    end else if (remainQ == '0) begin
      busyQ <= 1'b0;
    end else begin
      remainQ <= remainQ - 1'b1;
    end
  end

  always_comb begin
    strobes.loadPgm    = takePgm;
    strobes.loadErase  = takeErase;
    strobes.flipToggle = busyQ && readStrobe;
    strobes.busy       = busyQ;
  end
endmodule

// File: rtl/prs_dpath.sv
module prs_dpath
  import prs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  prsStrobes_t strobes,
  input  logic [7:0]  lastData,
  input  logic [7:0]  arrayData,
  output logic [7:0]  readData
);
  logic pollBitQ;
  logic toggleQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollBitQ <= 1'b0;
      toggleQ  <= 1'b0;
    end else if (strobes.loadErase) begin
      pollBitQ <= 1'b0;
      toggleQ  <= 1'b0;
    end else if (strobes.loadPgm) begin
      pollBitQ <= ~lastData[7];
      toggleQ  <= 1'b0;
    end else if (strobes.flipToggle) begin
      toggleQ  <= ~toggleQ;
    end
  end

  assign readData = strobes.busy ? {pollBitQ, toggleQ, 6'b000000} : arrayData;
endmodule

// File: rtl/prs_top.sv
module prs_top
  import prs_pkg::*;
#(
  parameter int PGM_CYCLES   = 1250000,
  parameter int ERASE_CYCLES = 6250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pgmStart,
  input  logic       eraseStart,
  input  logic [7:0] lastData,
  input  logic       readStrobe,
  input  logic [7:0] arrayData,
  output logic       busy,
  output logic [7:0] readData
);
  prsStrobes_t strobes;

  prs_ctrl #(.PGM_CYCLES(PGM_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .pgmStart(pgmStart), .eraseStart(eraseStart),
    .readStrobe(readStrobe), .strobes(strobes)
  );

  prs_dpath dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lastData(lastData),
    .arrayData(arrayData), .readData(readData)
  );

  assign busy = strobes.busy;
endmodule

// File: rtl/prs_checker.sv
module prs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pgmStart,
  input logic       eraseStart,
  input logic       readStrobe,
  input logic [7:0] arrayData,
  input logic       busy,
  input logic [7:0] readData
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ((pgmStart || eraseStart) && !busy) |=> busy); // R2
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (readData[5:0] == 6'd0)); // R7
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (readData == arrayData)); // R8
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && readStrobe) ##1 busy |-> (readData[6] != $past(readData[6]))); // R6
  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !readStrobe) ##1 busy |-> $stable(readData[6])); // R6
  AST_POLL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    busy ##1 busy |-> $stable(readData[7])); // R9
endmodule

bind prs_top prs_checker chk (
  .clk(clk), .rstN(rstN), .pgmStart(pgmStart), .eraseStart(eraseStart),
  .readStrobe(readStrobe), .arrayData(arrayData), .busy(busy), .readData(readData)
);

// File: tb/prs_top_test.sv
module prs_top_test;
  localparam int PGC = 7;
  localparam int ERC = 19;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pgmStart = 1'b0;
  logic       eraseStart = 1'b0;
  logic [7:0] lastData = 8'h00;
  logic       readStrobe = 1'b0;
  logic [7:0] arrayData = 8'h00;
  logic       busy;
  logic [7:0] readData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prs_top #(.PGM_CYCLES(PGC), .ERASE_CYCLES(ERC)) uut (
    .clk(clk), .rstN(rstN), .pgmStart(pgmStart), .eraseStart(eraseStart),
    .lastData(lastData), .readStrobe(readStrobe), .arrayData(arrayData),
    .busy(busy), .readData(readData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // er/pg: start pulses; pat: read strobe mask per busy cycle; poke: start pulse mid-run
  task automatic runOp(input bit er, input bit pg, input logic [7:0] ld,
                       input logic [31:0] pat, input bit poke);
    int dur = 0;
    int reads = 0;
    int expDur;
    logic expB7;
    @(negedge clk);
    pgmStart = pg; eraseStart = er; lastData = ld;
    @(negedge clk);
    pgmStart = 1'b0; eraseStart = 1'b0; lastData = ~ld;
    expDur = er ? ERC : PGC;
    expB7  = er ? 1'b0 : ~ld[7];
    while (busy && dur < 200) begin
      readStrobe = pat[dur % 32];
      arrayData = 8'(dur * 37 + 5);
      lastData = 8'(dur * 91);
      #1;
      check(er ? "R5 erase poll bit" : "R4 program poll bit", readData[7], expB7);
      check("R6 toggle bit", readData[6], reads % 2);
      check("R7 low bits zero", readData[5:0], 0);
      if (readStrobe) reads++;
      pgmStart = poke && (dur == 2);
      eraseStart = poke && (dur == 4);
      dur++;
      @(negedge clk);
    end
    readStrobe = 1'b0; pgmStart = 1'b0; eraseStart = 1'b0;
    check(er ? (pg ? "R10 both starts duration" : "R3 erase duration")
             : (poke ? "R9 ignored start duration" : "R2 program duration"), dur, expDur);
    arrayData = 8'hA5 ^ ld; readStrobe = 1'b1; #1;
    check("R8 idle pass-through", readData, 8'hA5 ^ ld);
    @(negedge clk);
    readStrobe = 1'b0; arrayData = 8'h3C; #1;
    check("R8 idle pass-through after read", {busy, readData}, {1'b0, 8'h3C});
  endtask

  initial begin
    logic [7:0] lds [6] = '{8'h00, 8'h80, 8'h7F, 8'hFF, 8'h55, 8'hAA};
    logic [31:0] pats [5] = '{32'h0, 32'hFFFFFFFF, 32'h55555555, 32'h33333333, 32'h0F0F1234};
    repeat (3) @(negedge clk);
    arrayData = 8'h9E; #1;
    check("R1 reset busy", busy, 0);
    check("R1 reset pass-through", readData, 8'h9E);
    rstN = 1'b1;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 5; j++)
        runOp(1'b0, 1'b1, lds[i], pats[j], 1'b0);
    for (int j = 0; j < 5; j++) runOp(1'b1, 1'b0, lds[j], pats[j], 1'b0);
    for (int j = 0; j < 3; j++) runOp(1'b1, 1'b1, lds[j + 1], pats[j], 1'b0);
    for (int i = 0; i < 4; i++) runOp(1'b0, 1'b1, lds[i], pats[i], 1'b1);
    runOp(1'b1, 1'b0, 8'h00, 32'h6, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule